// File: doc/BRIEF.md
# Permission-Checking Address Translation Cache

This block is a small, fully associative cache of page translations that sits between a processor and memory. Every address the processor issues is presented on the lookup port together with the kind of access (load, store or instruction fetch). The block compares the page number of that address with all stored translations at once. It reports one of three outcomes one cycle later:
- a translated physical address,
- a miss, so that a software handler can install the missing mapping,
- a protection fault, when the page is mapped but forbids that kind of access.

Translations are installed only by privileged software through a refill port. The refill port names the slot, the page pair, the three permission bits and a valid bit. A flush input drops every stored translation at once. There is no hardware walk of page tables. The offset within a page passes through unchanged.

Top module: `tlb_xlate`

## Requirements
- R1: After a synchronous active-low reset every slot is invalid, all result outputs are 0, and any lookup reports a miss.
- R2: A lookup whose page number (address bits 31:12) matches a valid slot whose permission allows the access reports hit, and the physical address is that slot's physical page in bits 31:12 with address bits 11:0 passed through.
- R3: Access kind 2'b00 (load) needs the read bit, 2'b01 (store) needs the write bit, and 2'b10 (fetch) needs the execute bit. Kind 2'b11 is never granted. A matching slot without the needed bit reports fault, with hit 0 and a physical address of 0.
- R4: A lookup that matches no valid slot reports miss with a physical address of 0.
- R5: While the result-valid output is 1, exactly one of hit, miss and fault is 1. While it is 0, all three flags and the physical address are 0.
- R6: When several valid slots hold the same page number, the lowest-numbered slot alone decides the outcome: its permission bits and its physical page are used.
- R7: The result for a lookup appears on the outputs on the clock edge that samples the lookup, so it is visible for exactly the following cycle. An idle cycle yields result-valid 0.
- R8: A refill writes slot, page pair, permission bits and valid bit at the next edge. A refill with valid 0 removes the slot. A lookup in the same cycle as a refill sees the slot contents from before the write.
- R9: Flush clears every valid bit at the next edge. A refill presented in the same cycle as a flush is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_valid | input | 1 | A lookup is presented this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 00 load, 01 store, 10 fetch, 11 reserved |
| flush | input | 1 | Invalidate all slots |
| rf_we | input | 1 | Refill write strobe |
| rf_idx | input | 4 | Slot number to write |
| rf_valid | input | 1 | Valid bit written to the slot |
| rf_vpn | input | 20 | Virtual page number written to the slot |
| rf_ppn | input | 20 | Physical page number written to the slot |
| rf_perm_r | input | 1 | Read permission written to the slot |
| rf_perm_w | input | 1 | Write permission written to the slot |
| rf_perm_x | input | 1 | Execute permission written to the slot |
| rs_valid | output | 1 | A result is present this cycle |
| rs_paddr | output | 32 | Translated physical address, 0 unless hit |
| rs_hit | output | 1 | Translation succeeded |
| rs_miss | output | 1 | No valid slot matched |
| rs_fault | output | 1 | Slot matched but access not permitted |

## Verification
The bench builds the block with its default parameters: 16 slots, 32-bit addresses and 12-bit page offsets. Random refills draw page numbers from a pool of only eight values. With 16 slots and eight page numbers, duplicate matches, overwritten slots and removed slots occur often. This puts the lowest-slot priority and the refill-versus-lookup ordering within reach alongside all four access kinds.

// File: rtl/tlb_xlate_pkg.sv
// Shared types for the translation cache: access kinds and permission bits.
package tlb_xlate_pkg;
    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_FETCH = 2'b10,
        ACC_RSVD  = 2'b11
    } acc_kind_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;
endpackage

// File: rtl/tlb_entry_store.sv
// Slot storage for the translation cache.
// Holds valid bit, page pair and permissions per slot. Writes happen at the
// clock edge, so same-cycle readers see old contents. Flush dominates refill.
// Assumes: writes with an index of ENTRIES or more are dropped.
module tlb_entry_store
    import tlb_xlate_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20,
    parameter int IDX_W   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic                          we,
    input  logic [IDX_W-1:0]              widx,
    input  logic                          wvalid,
    input  logic [VPN_W-1:0]              wvpn,
    input  logic [PPN_W-1:0]              wppn,
    input  perm_t                         wperm,
    output logic [ENTRIES-1:0]            ent_valid,
    output logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn,
    output logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn,
    output perm_t [ENTRIES-1:0]           ent_perm
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic sel;
        assign sel = we && (widx == IDX_W'(g));

        // Valid bit: cleared by reset or flush, set or cleared by refill.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                ent_valid[g] <= 1'b0;
            end else if (sel) begin
                ent_valid[g] <= wvalid;
            end
        end

        // Page pair and permissions: loaded by a refill that flush does not cancel.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_vpn[g]  <= '0;
                ent_ppn[g]  <= '0;
                ent_perm[g] <= '0;
            end else if (sel && !flush) begin
                ent_vpn[g]  <= wvpn;
                ent_ppn[g]  <= wppn;
                ent_perm[g] <= wperm;
            end
        end
    end

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ent_valid == '0));

    assert_refill_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !flush && (widx < IDX_W'(ENTRIES - 1) || widx == IDX_W'(ENTRIES - 1)))
        |=> (ent_valid[$past(widx)] == $past(wvalid)));
endmodule

// File: rtl/tlb_match.sv
// Parallel page-number compare with lowest-slot priority.
// Produces whether any valid slot matches and the lowest matching index.
// Assumes: combinational; clk and rst_n serve only the local assertion.
module tlb_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int IDX_W   = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ENTRIES-1:0]            ent_valid,
    input  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn,
    input  logic [VPN_W-1:0]              lk_vpn,
    output logic                          hit_any,
    output logic [IDX_W-1:0]              hit_idx
);
    logic [ENTRIES-1:0] match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = ent_valid[g] && (ent_vpn[g] == lk_vpn);
    end

    assign hit_any = |match;

    // Priority pick: scanning downward leaves the lowest matching index.
    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assert_lowest_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> (match[hit_idx] &&
                     ((match & ~({ENTRIES{1'b1}} << hit_idx)) == '0)));
endmodule

// File: rtl/tlb_perm_check.sv
// Grants or denies an access kind against one slot's permission bits.
// Assumes: the reserved access kind is never granted.
module tlb_perm_check
    import tlb_xlate_pkg::*;
(
    input  perm_t      perm,
    input  logic [1:0] acc,
    output logic       granted
);
    // Select the permission bit that the access kind needs.
    always_comb begin
        case (acc_kind_e'(acc))
            ACC_LOAD:  granted = perm.rd;
            ACC_STORE: granted = perm.wr;
            ACC_FETCH: granted = perm.ex;
            default:   granted = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlb_xlate.sv
// Fully associative translation cache with per-page read/write/execute checks.
// The lookup resolves combinationally, and hit/miss/fault plus the physical
// address are registered one cycle later. Slots are filled by software.
// Assumes: VA_W - PAGE_BITS equals the stored page-number width.
module tlb_xlate
    import tlb_xlate_pkg::*;
#(
    parameter int ENTRIES   = 16,
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int VPN_W    = VA_W - PAGE_BITS,
    localparam int PPN_W    = PA_W - PAGE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic [1:0]       lk_acc,
    input  logic             flush,
    input  logic             rf_we,
    input  logic [IDX_W-1:0] rf_idx,
    input  logic             rf_valid,
    input  logic [VPN_W-1:0] rf_vpn,
    input  logic [PPN_W-1:0] rf_ppn,
    input  logic             rf_perm_r,
    input  logic             rf_perm_w,
    input  logic             rf_perm_x,
    output logic             rs_valid,
    output logic [PA_W-1:0]  rs_paddr,
    output logic             rs_hit,
    output logic             rs_miss,
    output logic             rs_fault
);
    logic [ENTRIES-1:0]            ent_valid;
    logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn;
    logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn;
    perm_t [ENTRIES-1:0]           ent_perm;
    perm_t                         wperm;
    logic                          hit_any;
    logic [IDX_W-1:0]              hit_idx;
    logic                          granted;
    logic [VPN_W-1:0]              lk_vpn;
    logic [PAGE_BITS-1:0]          lk_off;

    assign lk_vpn = lk_vaddr[VA_W-1:PAGE_BITS];
    assign lk_off = lk_vaddr[PAGE_BITS-1:0];
    assign wperm  = '{rd: rf_perm_r, wr: rf_perm_w, ex: rf_perm_x};

    tlb_entry_store #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .IDX_W(IDX_W)
    ) store_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .we(rf_we), .widx(rf_idx),
        .wvalid(rf_valid), .wvpn(rf_vpn), .wppn(rf_ppn), .wperm(wperm),
        .ent_valid(ent_valid), .ent_vpn(ent_vpn), .ent_ppn(ent_ppn),
        .ent_perm(ent_perm)
    );

    tlb_match #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .IDX_W(IDX_W)
    ) match_i (
        .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_vpn(ent_vpn),
        .lk_vpn(lk_vpn), .hit_any(hit_any), .hit_idx(hit_idx)
    );

    tlb_perm_check perm_i (
        .perm(ent_perm[hit_idx]), .acc(lk_acc), .granted(granted)
    );

    // Result register: capture the outcome of this cycle's lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid <= 1'b0;
            rs_hit   <= 1'b0;
            rs_miss  <= 1'b0;
            rs_fault <= 1'b0;
            rs_paddr <= '0;
        end else begin
            rs_valid <= lk_valid;
            rs_hit   <= lk_valid && hit_any && granted;
            rs_miss  <= lk_valid && !hit_any;
            rs_fault <= lk_valid && hit_any && !granted;
            rs_paddr <= (lk_valid && hit_any && granted) ?
                        {ent_ppn[hit_idx], lk_off} : '0;
        end
    end

    assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> ($countones({rs_hit, rs_miss, rs_fault}) == 1));

    assert_quiet_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |-> (!rs_hit && !rs_miss && !rs_fault && rs_paddr == '0));

    assert_next_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid);

    assert_offset_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rs_hit || rs_paddr[PAGE_BITS-1:0] == $past(lk_off)));

    assert_no_leak_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_hit |-> (rs_paddr == '0));
endmodule

// File: tb/tlb_xlate_tb_top.sv
module tlb_xlate_tb_top;
    localparam int ENT = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_acc = '0;
    logic        flush = 1'b0;
    logic        rf_we = 1'b0;
    logic [3:0]  rf_idx = '0;
    logic        rf_valid = 1'b0;
    logic [19:0] rf_vpn = '0;
    logic [19:0] rf_ppn = '0;
    logic        rf_perm_r = 1'b0, rf_perm_w = 1'b0, rf_perm_x = 1'b0;
    logic        rs_valid, rs_hit, rs_miss, rs_fault;
    logic [31:0] rs_paddr;

    logic        m_v   [ENT];
    logic [19:0] m_vpn [ENT];
    logic [19:0] m_ppn [ENT];
    logic [2:0]  m_p   [ENT];   // {r,w,x}

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    tlb_xlate dut_i (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_acc(lk_acc), .flush(flush), .rf_we(rf_we), .rf_idx(rf_idx),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
        .rf_perm_r(rf_perm_r), .rf_perm_w(rf_perm_w), .rf_perm_x(rf_perm_x),
        .rs_valid(rs_valid), .rs_paddr(rs_paddr), .rs_hit(rs_hit),
        .rs_miss(rs_miss), .rs_fault(rs_fault)
    );

    function automatic logic [35:0] dut_res();
        return {rs_valid, rs_hit, rs_miss, rs_fault, rs_paddr};
    endfunction

    // Expected {valid,hit,miss,fault,paddr} from the bench's slot model.
    function automatic logic [35:0] model_res(input logic [31:0] va, input logic [1:0] acc);
        bit found = 1'b0;
        int idx = 0;
        bit ok;
        for (int i = 0; i < ENT; i++) begin
            if (!found && m_v[i] && m_vpn[i] == va[31:12]) begin
                found = 1'b1;
                idx = i;
            end
        end
        if (!found) return {4'b1010, 32'h0};
        case (acc)
            2'b00:   ok = m_p[idx][2];
            2'b01:   ok = m_p[idx][1];
            2'b10:   ok = m_p[idx][0];
            default: ok = 1'b0;
        endcase
        if (ok) return {4'b1100, m_ppn[idx], va[11:0]};
        return {4'b1001, 32'h0};
    endfunction

    task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < ENT; i++) m_v[i] = 1'b0;
    endtask

    task automatic drive_refill(input int idx, input bit v, input logic [19:0] vpn,
                                input logic [19:0] ppn, input logic [2:0] p);
        rf_we = 1'b1; rf_idx = 4'(idx); rf_valid = v; rf_vpn = vpn; rf_ppn = ppn;
        rf_perm_r = p[2]; rf_perm_w = p[1]; rf_perm_x = p[0];
    endtask

    task automatic model_refill(input int idx, input bit v, input logic [19:0] vpn,
                                input logic [19:0] ppn, input logic [2:0] p);
        m_v[idx] = v; m_vpn[idx] = vpn; m_ppn[idx] = ppn; m_p[idx] = p;
    endtask

    task automatic refill(input int idx, input bit v, input logic [19:0] vpn,
                          input logic [19:0] ppn, input logic [2:0] p);
        @(negedge clk);
        drive_refill(idx, v, vpn, ppn, p);
        @(negedge clk);
        rf_we = 1'b0;
        model_refill(idx, v, vpn, ppn, p);
    endtask

    task automatic lookup(input logic [31:0] va, input logic [1:0] acc, input string req);
        logic [35:0] exp;
        exp = model_res(va, acc);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_acc = acc;
        @(negedge clk);
        lk_valid = 1'b0;
        check(dut_res() == exp, req, dut_res(), exp);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL R7 watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [35:0] exp;
        void'($urandom(32'h5eed_0042));
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dut_res() == 36'h0, "R1 reset outputs", dut_res(), 36'h0);
        lookup(32'h1234_5678, 2'b00, "R1 lookup after reset misses");

        // R2/R3: read-only page.
        refill(3, 1'b1, 20'h00010, 20'hABCDE, 3'b100);
        lookup(32'h0001_0123, 2'b00, "R2 load hit");
        lookup(32'h0001_0123, 2'b01, "R3 store on read-only faults");
        lookup(32'h0001_0123, 2'b10, "R3 fetch on read-only faults");
        refill(4, 1'b1, 20'h00020, 20'h0F0F0, 3'b111);
        lookup(32'h0002_0FFF, 2'b10, "R3 fetch on rwx hits");
        lookup(32'h0002_0FFF, 2'b11, "R3 reserved kind faults");
        lookup(32'h0009_0000, 2'b00, "R4 unmapped page misses");

        // R7: idle cycle right after a result.
        @(negedge clk);
        check(dut_res() == 36'h0, "R7 idle cycle gives no result", dut_res(), 36'h0);

        // R6: duplicate page, lowest slot decides.
        refill(9, 1'b1, 20'h00030, 20'h11111, 3'b111);
        refill(2, 1'b1, 20'h00030, 20'h22222, 3'b010);
        lookup(32'h0003_0ABC, 2'b00, "R6 lowest slot perms fault");
        lookup(32'h0003_0ABC, 2'b01, "R6 lowest slot ppn used");
        refill(2, 1'b0, 20'h00030, 20'h22222, 3'b010);
        lookup(32'h0003_0ABC, 2'b00, "R8 removed slot falls to next");

        // R8: refill and lookup in the same cycle.
        exp = model_res(32'h0003_0ABC, 2'b00);
        @(negedge clk);
        drive_refill(9, 1'b1, 20'h00030, 20'h33333, 3'b100);
        lk_valid = 1'b1; lk_vaddr = 32'h0003_0ABC; lk_acc = 2'b00;
        @(negedge clk);
        rf_we = 1'b0; lk_valid = 1'b0;
        check(dut_res() == exp, "R8 same-cycle lookup sees old slot", dut_res(), exp);
        model_refill(9, 1'b1, 20'h00030, 20'h33333, 3'b100);
        lookup(32'h0003_0ABC, 2'b00, "R8 refill visible next cycle");

        // R9: flush with a simultaneous refill.
        @(negedge clk);
        drive_refill(5, 1'b1, 20'h00040, 20'h44444, 3'b111);
        flush = 1'b1;
        @(negedge clk);
        rf_we = 1'b0; flush = 1'b0;
        clear_model();
        lookup(32'h0004_0000, 2'b00, "R9 refill under flush dropped");
        lookup(32'h0001_0123, 2'b00, "R9 flush removed old slot");

        // Random mix against the model.
        for (int n = 0; n < 800; n++) begin
            int r = $urandom_range(0, 99);
            if (r < 30) begin
                refill($urandom_range(0, ENT - 1), ($urandom_range(0, 4) != 0),
                       20'hA5000 | 20'($urandom_range(0, 7)), 20'($urandom),
                       3'($urandom_range(0, 7)));
            end else if (r < 33) begin
                @(negedge clk);
                flush = 1'b1;
                @(negedge clk);
                flush = 1'b0;
                clear_model();
            end else begin
                lookup({20'hA5000 | 20'($urandom_range(0, 8)), 12'($urandom)},
                       2'($urandom_range(0, 3)), "R2/R3/R4/R5/R6 random lookup");
            end
        end

        done = 1'b1;
        finish_run();
    end
endmodule